// File: doc/BRIEF.md
# I2C serial memory slave controller

This block is an I2C target that fronts a small on-chip byte memory whose depth is set by a parameter. It watches filtered SCL and SDA for start and stop conditions and decodes the control byte: seven device-address bits followed by a read/write bit. A write transaction carries a word address and then one data byte. The data byte is held in a staging register. The array is written only after the stop condition, at the end of an internally timed write cycle. While that cycle runs the block answers no control byte, so a master can poll for completion.

Reads use a single address pointer that is kept between transactions. The pointer supports three read modes:
- A current-address read continues from wherever the last access left off.
- A random read sets the pointer with an address-only write, then issues a repeated start and a read.
- A sequential read keeps streaming bytes for as long as the master acknowledges them, and wraps at the top of the array.

A write-protect input makes the whole array read-only. SDA is open-drain: the block only ever pulls it low.

Top module: `i2c_mem_slave`

## Requirements
- R1: SCL and SDA each pass a two-flop synchronizer and a filter that accepts a new level only after it has held for FILT_LEN consecutive clocks; shorter pulses have no effect. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high.
- R2: The first byte after a start is the control byte. Bits 7..1 are compared with DEV_ADDR, and bit 0 is R/W with 1 meaning read. On a match the block pulls SDA low during the ninth SCL pulse (ACK). On a mismatch it leaves SDA released and stays silent until the next start.
- R3: In a write transaction the byte after the control byte is the word address. Its low ADDR_W bits are loaded into the address pointer, and the byte is acknowledged.
- R4: The first data byte after the word address is acknowledged and staged for the current pointer value, and the pointer then advances by one. It is written into the array only after a stop, on the last clock of a WRITE_CYCLES-clock internal cycle. A second data byte in the same transaction is not acknowledged and is never written.
- R5: While the internal write cycle runs, no control byte is acknowledged. The first control byte after the cycle ends is acknowledged.
- R6: A start condition that arrives before the stop discards a staged data byte: no write cycle begins and the array is unchanged. An address-only write followed by a repeated start and a read control byte therefore reads from the new address.
- R7: After an acknowledged read control byte, the block sends the byte at the pointer, MSB first. The pointer advances by one when the eighth bit is done.
- R8: If the master acknowledges a read byte (SDA low in the ninth pulse), the next sequential byte follows. If the master does not acknowledge it, SDA stays released until the next start.
- R9: The pointer persists between transactions, so a current-address read after an access to address n returns the byte at n+1.
- R10: The pointer wraps from 2**ADDR_W-1 to 0 on both reads and writes, and one sequential read can cover the whole array and continue past the end.
- R11: If the write-protect input is high at the stop condition, no write cycle starts, the array is unchanged, and the next control byte is acknowledged at once.
- R12: Reset releases SDA, clears the pointer to 0 and cancels any write cycle. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level as seen on the bus |
| wp_i | input | 1 | Write protect; high blocks programming |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench builds the block with these parameter values:
- ADDR_W = 4. The array has 16 bytes, so the pointer wraps after the bench fills the array, and one sequential read crosses the top of the array.
- WRITE_CYCLES = 600. This is long enough that an acknowledge poll sent right after a stop lands inside the write cycle, and short enough to run many write cycles.
- FILT_LEN = 3. Two-clock SCL glitches inserted in a read byte stay below the filter threshold and must not shift the transmitted bits.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_CTRL,
    S_ADDR,
    S_WDATA,
    S_ACK,
    S_TX,
    S_MACK,
    S_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_TOP) begin
        dout  <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
endmodule

// File: rtl/i2c_wcycle_timer.sv
module i2c_wcycle_timer #(
  parameter int WRITE_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(WRITE_CYCLES + 1);
  localparam logic [TW-1:0] LOAD_VAL = TW'(WRITE_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  assign done = busy && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (launch && !busy) begin
      busy  <= 1'b1;
      cnt_q <= LOAD_VAL;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter logic [6:0]  DEV_ADDR     = 7'h50,
  parameter int          WRITE_CYCLES = 5000,
  parameter int          FILT_LEN     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] lines_raw, lines_f;
  logic scl_f, sda_f;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic [1:0] wp_sync;
  logic wp_s;

  slv_state_e        st, ret_st;
  logic [2:0]        bitcnt;
  logic [7:0]        shreg;
  logic              byte_full;
  logic              mack;
  logic [ADDR_W-1:0] ptr;
  logic              pend;
  logic [ADDR_W-1:0] stg_addr;
  logic [7:0]        stg_data;
  logic [7:0]        rd_q;
  logic              wc_busy, mem_we, wc_launch;

  assign lines_raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .din  (lines_raw[g]),
      .dout (lines_f[g])
    );
  end

  assign scl_f = lines_f[1];
  assign sda_f = lines_f[0];

  i2c_cond_detect u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) wp_sync <= 2'b00;
    else     wp_sync <= {wp_sync[0], wp_i};
  end
  assign wp_s = wp_sync[1];

  assign wc_launch = stop_det && pend && !wp_s;

  i2c_wcycle_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .launch (wc_launch),
    .busy   (wc_busy),
    .done   (mem_we)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (stg_addr),
    .wdata (stg_data),
    .raddr (ptr),
    .rdata (rd_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      ret_st    <= S_IDLE;
      bitcnt    <= 3'd0;
      shreg     <= 8'd0;
      byte_full <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      ptr       <= '0;
      pend      <= 1'b0;
      stg_addr  <= '0;
      stg_data  <= 8'd0;
    end else if (start_det) begin
      st        <= S_CTRL;
      bitcnt    <= 3'd0;
      byte_full <= 1'b0;
      sda_oe    <= 1'b0;
      pend      <= 1'b0;
    end else if (stop_det) begin
      st        <= S_IDLE;
      byte_full <= 1'b0;
      sda_oe    <= 1'b0;
      pend      <= 1'b0;
    end else begin
      unique case (st)
        S_CTRL, S_ADDR, S_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) byte_full <= 1'b1;
          end else if (scl_fall && byte_full) begin
            byte_full <= 1'b0;
            if (st == S_CTRL) begin
              if (shreg[7:1] == DEV_ADDR && !wc_busy) begin
                sda_oe <= 1'b1;
                st     <= S_ACK;
                ret_st <= shreg[0] ? S_TX : S_ADDR;
              end else begin
                st <= S_IGNORE;
              end
            end else if (st == S_ADDR) begin
              ptr    <= shreg[ADDR_W-1:0];
              sda_oe <= 1'b1;
              st     <= S_ACK;
              ret_st <= S_WDATA;
            end else if (!pend) begin
              stg_addr <= ptr;
              stg_data <= shreg;
              ptr      <= ptr + 1'b1;
              pend     <= 1'b1;
              sda_oe   <= 1'b1;
              st       <= S_ACK;
              ret_st   <= S_WDATA;
            end else begin
              st <= S_IGNORE;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            bitcnt <= 3'd0;
            if (ret_st == S_TX) begin
              shreg  <= rd_q;
              sda_oe <= ~rd_q[7];
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ret_st;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              st     <= S_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_f;
          end else if (scl_fall) begin
            bitcnt <= 3'd0;
            if (mack) begin
              shreg  <= rd_q;
              sda_oe <= ~rd_q[7];
              st     <= S_TX;
            end else begin
              st <= S_IGNORE;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk
  import i2c_mem_pkg::*;
#(
  parameter int         ADDR_W       = 8,
  parameter logic [6:0] DEV_ADDR     = 7'h50,
  parameter int         WRITE_CYCLES = 5000
) (
  input logic              clk,
  input logic              rst,
  input slv_state_e        st,
  input logic              byte_full,
  input logic              scl_fall,
  input logic              scl_f,
  input logic              stop_det,
  input logic [7:0]        shreg,
  input logic [2:0]        bitcnt,
  input logic [ADDR_W-1:0] ptr,
  input logic              wc_busy,
  input logic              wp_s,
  input logic              mem_we,
  input logic              sda_oe
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst || !wc_busy) busy_run <= 0;
    else                 busy_run <= busy_run + 1;
  end

  AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe)); // R1

  AST_MISMATCH_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (st == S_CTRL && byte_full && scl_fall && shreg[7:1] != DEV_ADDR)
      |=> (!sda_oe && st == S_IGNORE)); // R2

  AST_COMMIT_AT_CYCLE_END: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (busy_run == WRITE_CYCLES - 1)); // R4

  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (st == S_CTRL && byte_full && scl_fall && wc_busy) |=> !sda_oe); // R5

  AST_PTR_STEP_AFTER_TX: assert property (@(posedge clk) disable iff (rst)
    (st == S_TX && scl_fall && bitcnt == 3'd7)
      |=> (ptr == ADDR_W'($past(ptr) + 1'b1) && !sda_oe)); // R7

  AST_WP_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (stop_det && wp_s && !wc_busy) |=> !wc_busy); // R11
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(
  .ADDR_W       (ADDR_W),
  .DEV_ADDR     (DEV_ADDR),
  .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .st        (st),
  .byte_full (byte_full),
  .scl_fall  (scl_fall),
  .scl_f     (scl_f),
  .stop_det  (stop_det),
  .shreg     (shreg),
  .bitcnt    (bitcnt),
  .ptr       (ptr),
  .wc_busy   (wc_busy),
  .wp_s      (wp_s),
  .mem_we    (mem_we),
  .sda_oe    (sda_oe)
);

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int WC    = 600;
  localparam int FL    = 3;
  localparam int HALF  = 20;
  localparam int Q     = 10;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [7:0] CW_B = {DEV, 1'b0};
  localparam logic [7:0] CR_B = {DEV, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_oe = 1'b0;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;

  assign sda_line = !(m_oe || sda_oe);

  always #10 clk = ~clk;

  i2c_mem_slave #(
    .ADDR_W(AW), .DEV_ADDR(DEV), .WRITE_CYCLES(WC), .FILT_LEN(FL)
  ) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .wp_i(wp), .sda_oe(sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit run_done = 0;
  int exp_q[$];
  int obs_q[$];
  string tag_q[$];
  logic [7:0] model [DEPTH];

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(string t, int v);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        int o;
        int e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (o != e) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", t, o, e);
        end
      end
    end
  end

  task automatic bus_start();
    m_oe = 1'b0; tick(Q);
    m_scl = 1'b1; tick(HALF);
    m_oe = 1'b1; tick(HALF);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_oe = 1'b1; tick(Q);
    m_scl = 1'b1; tick(HALF);
    m_oe = 1'b0; tick(HALF);
  endtask

  task automatic put_bit(logic b);
    m_oe = !b; tick(Q);
    m_scl = 1'b1; tick(HALF);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] b, int exp_ack, string t);
    expect_val(t, exp_ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_oe = 1'b0; tick(Q);
    m_scl = 1'b1; tick(HALF / 2);
    obs_q.push_back(sda_line ? 0 : 1);
    tick(HALF / 2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_byte(logic ack, logic glitch, int exp_v, string t);
    logic [7:0] v;
    v = 8'd0;
    expect_val(t, exp_v);
    for (int i = 0; i < 8; i++) begin
      m_oe = 1'b0;
      if (glitch) begin
        tick(3); m_scl = 1'b1; tick(2); m_scl = 1'b0; tick(Q - 5);
      end else begin
        tick(Q);
      end
      m_scl = 1'b1; tick(HALF / 2);
      v = {v[6:0], sda_line};
      tick(HALF / 2);
      m_scl = 1'b0; tick(Q);
    end
    obs_q.push_back(int'(v));
    m_oe = ack; tick(Q);
    m_scl = 1'b1; tick(HALF);
    m_scl = 1'b0; tick(Q);
    m_oe = 1'b0;
  endtask

  task automatic write_one(int a, logic [7:0] d);
    bus_start();
    send_byte(CW_B, 1, "R2 write ctrl ack");
    send_byte(8'(a), 1, "R3 word addr ack");
    send_byte(d, 1, "R4 data ack");
    bus_stop();
  endtask

  task automatic rand_read(int a, int n, string t);
    bus_start();
    send_byte(CW_B, 1, t);
    send_byte(8'(a), 1, t);
    bus_start();
    send_byte(CR_B, 1, t);
    for (int i = 0; i < n; i++)
      get_byte(i != n - 1, 1'b0, int'(model[(a + i) % DEPTH]), t);
    bus_stop();
  endtask

  task automatic cur_read(int a, string t);
    bus_start();
    send_byte(CR_B, 1, "R7 read ctrl ack");
    get_byte(1'b0, 1'b0, int'(model[a % DEPTH]), t);
    bus_stop();
  endtask

  task automatic finish_run();
    if (!run_done) begin
      run_done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    tick(190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    tick(5);
    n_chk++;
    if (sda_oe !== 1'b0 || sda_line !== 1'b1) begin
      n_fail++;
      $display("FAIL R12 reset: actual %0b expected 0", sda_oe);
    end
    rst = 1'b0;
    tick(10);

    // first write, then poll during the internal cycle (R4, R5)
    write_one(0, 8'd11);
    model[0] = 8'd11;
    bus_start();
    send_byte(CW_B, 0, "R5 no ack while busy");
    bus_stop();
    tick(WC + 100);
    bus_start();
    send_byte(CW_B, 1, "R5 ack after cycle");
    bus_stop();

    // fill the rest of the array
    for (int i = 1; i < DEPTH; i++) begin
      model[i] = 8'((i * 37 + 11) & 8'hFF);
      write_one(i, model[i]);
      tick(WC + 100);
    end

    // pointer wrapped after address 15 (R10), current reads (R9)
    cur_read(0, "R10 pointer wrapped after last write");
    cur_read(1, "R9 current read returns n+1");

    // random read (R6), then persistence (R9)
    rand_read(9, 1, "R6 random read");
    cur_read(10, "R9 pointer persists across transactions");

    // staged byte discarded by repeated start (R6)
    bus_start();
    send_byte(CW_B, 1, "R6 ctrl");
    send_byte(8'd3, 1, "R6 addr");
    send_byte(8'h5A, 1, "R6 staged data ack");
    bus_start();
    send_byte(CR_B, 1, "R6 read ctrl");
    get_byte(1'b0, 1'b0, int'(model[4]), "R6 read after staged byte");
    bus_stop();
    bus_start();
    send_byte(CW_B, 1, "R6 no write cycle started");
    bus_stop();
    rand_read(3, 1, "R6 discarded byte not written");

    // sequential read across the top (R8, R10), silence after NACK (R8)
    bus_start();
    send_byte(CW_B, 1, "R8 ctrl");
    send_byte(8'd12, 1, "R8 addr");
    bus_start();
    send_byte(CR_B, 1, "R8 read ctrl");
    for (int i = 0; i < DEPTH + 2; i++)
      get_byte(i != DEPTH + 1, 1'b0, int'(model[(12 + i) % DEPTH]), "R10 R8 sequential read");
    get_byte(1'b0, 1'b0, 8'hFF, "R8 silent after master nack");
    bus_stop();

    // mismatched control byte (R2); pointer is now 14
    bus_start();
    send_byte(8'hB0, 0, "R2 wrong address write nack");
    get_byte(1'b0, 1'b0, 8'hFF, "R2 silent after mismatch");
    bus_stop();
    bus_start();
    send_byte(8'hA3, 0, "R2 wrong address read nack");
    bus_stop();
    cur_read(14, "R2 pointer untouched by mismatch");

    // second data byte refused (R4)
    bus_start();
    send_byte(CW_B, 1, "R4 ctrl");
    send_byte(8'd5, 1, "R4 addr");
    send_byte(8'h11, 1, "R4 first data ack");
    send_byte(8'h22, 0, "R4 second data nack");
    bus_stop();
    tick(WC + 100);
    model[5] = 8'h11;
    rand_read(5, 2, "R4 one byte committed");

    // write protect (R11)
    wp = 1'b1;
    tick(5);
    write_one(7, 8'hC3);
    bus_start();
    send_byte(CW_B, 1, "R11 no cycle under write protect");
    bus_stop();
    wp = 1'b0;
    tick(5);
    rand_read(7, 1, "R11 array unchanged");

    // SCL glitches inside a read byte (R1)
    bus_start();
    send_byte(CW_B, 1, "R1 ctrl");
    send_byte(8'd2, 1, "R1 addr");
    bus_start();
    send_byte(CR_B, 1, "R1 read ctrl");
    get_byte(1'b0, 1'b1, int'(model[2]), "R1 glitches filtered");
    bus_stop();

    // reset clears the pointer but keeps the array (R12)
    rst = 1'b1;
    tick(5);
    rst = 1'b0;
    tick(10);
    cur_read(0, "R12 pointer zero after reset");

    tick(200);
    finish_run();
  end
endmodule